// File: doc/BRIEF.md
# E1 Timeslot-Zero Framer and Multiplexer

This block builds the timeslot-zero byte of a 2.048 Mbit/s PCM frame with 32 timeslots. It merges that byte into the serial NRZ stream that carries the other 31 timeslots. An external active-high pulse, eight bit clocks long, marks timeslot zero. While the pulse is high, the merged output carries the generated byte. At all other times it carries the serial data input unchanged. The merged stream leaves on a dedicated output so that a line encoder and other consumers can use it.

Frames alternate between two kinds. A sync frame carries an international bit followed by the seven-bit frame alignment word. A non-sync frame carries a second international bit, a forced one that keeps the alignment word from being imitated, and six user bits. A frame-type indicator is high throughout every sync frame, including its timeslot zero. It changes one clock after timeslot zero ends. The international and user inputs are taken in the first bit clock of each timeslot zero, so changes later in the byte do not corrupt it.

Top module: `e1_ts0_mux`

## Requirements
- R1: After reset, `sync_ind` is 1 and the first timeslot zero carries sync-frame content.
- R2: In a sync frame, timeslot-zero bit 1 is `intl_sync`. Bits 2 to 8 are 0,0,1,1,0,1,1 in that order.
- R3: In a non-sync frame, bit 1 is `intl_nsync` and bit 2 is 1. Bits 3 to 8 are `user_bits[5]` down to `user_bits[0]`, so `user_bits[5]` goes out as bit 3.
- R4: Frame kinds strictly alternate, one sync frame and then one non-sync frame, starting with sync.
- R5: While `ts0_mark` is low, `mux_out` equals `ser_in` in the same cycle. While `ts0_mark` is high, `ser_in` has no effect on `mux_out`.
- R6: Bit 1 goes out in the first cycle in which `ts0_mark` is high, and bits follow one per clock, bit 1 first. Every rising edge of `ts0_mark` restarts the sequence at bit 1, even if the previous pulse was cut short.
- R7: `sync_ind` changes only at the clock edge that follows the first low cycle after `ts0_mark` falls. It inverts there and holds its value at every other edge.
- R8: `intl_sync`, `intl_nsync` and `user_bits` are sampled in the first cycle of timeslot zero. A change to them in later cycles of the same byte does not alter bits 2 to 8.
- R9: `rst_n` is a synchronous active-low reset. Asserting it in the middle of operation returns `sync_ind` to 1 and the next frame to sync content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | NRZ data for timeslots 1 to 31 |
| ts0_mark | input | 1 | High for the 8 bit periods of timeslot zero |
| intl_sync | input | 1 | International bit for bit 1 of sync frames |
| intl_nsync | input | 1 | International bit for bit 1 of non-sync frames |
| user_bits | input | 6 | Bits 3 to 8 of non-sync frames; bit 5 goes out first |
| mux_out | output | 1 | Merged NRZ stream |
| sync_ind | output | 1 | High during sync frames, changes one clock after timeslot zero |

## Verification
On every cycle, the assertions check that the frame-type indicator inverts exactly once after each falling edge of the marker and holds otherwise. They also check that the bit counter restarts on each rising edge, that the alignment word appears in bits 2 to 8 of sync frames, that bit 2 of non-sync frames is forced to one, and that the indicator is set after reset. Other behaviours can only be shown by the bench's directed scenarios, because they depend on the data on the inputs over a whole byte. These are the per-bit content of both frame kinds, the pass-through of serial data, the capture of the field inputs in the first cycle when they later change in the same byte, the restart after a truncated marker pulse, and recovery from a reset in the middle of a stream.

// File: rtl/e1_ts0_pkg.sv
// Shared constants and types for the E1 timeslot-zero framer.
// Assumes a fixed 8-bit timeslot with bit 1 transmitted first.
package e1_ts0_pkg;
    localparam int TS0_BITS = 8;
    localparam logic [TS0_BITS-2:0] FAS_WORD = 7'b0011011;

    typedef enum logic {
        FRM_NONSYNC = 1'b0,
        FRM_SYNC    = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/e1_ts0_timing.sv
// Timing for timeslot zero: finds the edges of the marker, counts bit
// positions inside the byte and alternates the frame kind.
// Assumes the marker is synchronous to clk and is normally TS_BITS cycles long.
module e1_ts0_timing
    import e1_ts0_pkg::*;
#(
    parameter int TS_BITS = TS0_BITS,
    localparam int CNT_W = $clog2(TS_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts0_mark,
    output logic             ts0_start,
    output logic [CNT_W-1:0] bit_idx,
    output logic             frame_sync
);
    logic             mark_q;
    logic [CNT_W-1:0] cnt_q;
    frame_kind_e      kind_q;
    logic             ts0_end;

    // Detect the edges of the marker using the value it had last cycle.
    always_comb begin
        ts0_start  = ts0_mark & ~mark_q;
        ts0_end    = mark_q & ~ts0_mark;
        bit_idx    = ts0_start ? '0 : cnt_q;
        frame_sync = (kind_q == FRM_SYNC);
    end

    // Remember the marker level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= 1'b0;
        else        mark_q <= ts0_mark;
    end

    // Position counter: restart on the rising edge, advance while marked.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (ts0_start) cnt_q <= CNT_W'(1);
        else if (ts0_mark)  cnt_q <= cnt_q + CNT_W'(1);
        else                cnt_q <= '0;
    end

    // Frame kind: sync after reset, inverted once per end of timeslot zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       kind_q <= FRM_SYNC;
        else if (ts0_end) kind_q <= (kind_q == FRM_SYNC) ? FRM_NONSYNC : FRM_SYNC;
    end

    // R7: the kind flips at the edge after the marker falls.
    a_r7_flip_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_q && !ts0_mark) |=> (frame_sync != $past(frame_sync)));

    // R7: no other edge changes the kind.
    a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_q && !ts0_mark) |=> $stable(frame_sync));

    // R6: a rising marker is followed by bit position 1.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ts0_start |=> (!ts0_mark || bit_idx == CNT_W'(1)));
endmodule

// File: rtl/e1_ts0_byte_gen.sv
// Builds the timeslot-zero bit for the current position. Holds the field
// inputs from the first cycle of the byte and uses the live inputs in that
// first cycle. Assumes bit_idx is 0 in the start cycle.
module e1_ts0_byte_gen
    import e1_ts0_pkg::*;
#(
    parameter int                  TS_BITS = TS0_BITS,
    parameter logic [TS_BITS-2:0]  ALIGN   = FAS_WORD,
    localparam int CNT_W  = $clog2(TS_BITS),
    localparam int USER_W = TS_BITS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts0_start,
    input  logic              frame_sync,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              intl_sync,
    input  logic              intl_nsync,
    input  logic [USER_W-1:0] user_bits,
    output logic              ts0_bit
);
    logic              hold_s_q;
    logic              hold_n_q;
    logic [USER_W-1:0] hold_u_q;
    logic [TS_BITS-1:0] byte_live;
    logic [TS_BITS-1:0] byte_held;
    logic [TS_BITS-1:0] byte_sel;

    // Capture the field inputs in the first cycle of each timeslot zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_s_q <= 1'b0;
            hold_n_q <= 1'b0;
            hold_u_q <= '0;
        end else if (ts0_start) begin
            hold_s_q <= intl_sync;
            hold_n_q <= intl_nsync;
            hold_u_q <= user_bits;
        end
    end

    // Assemble the byte, bit 1 in the MSB, and pick the bit for this position.
    always_comb begin
        byte_live = frame_sync ? {intl_sync, ALIGN} : {intl_nsync, 1'b1, user_bits};
        byte_held = frame_sync ? {hold_s_q, ALIGN}  : {hold_n_q, 1'b1, hold_u_q};
        byte_sel  = ts0_start ? byte_live : byte_held;
        ts0_bit   = byte_sel[CNT_W'(TS_BITS-1) - bit_idx];
    end
endmodule

// File: rtl/e1_ts0_mux.sv
// Top of the E1 timeslot-zero framer: selects the generated byte while the
// marker is high and the serial stream otherwise, and drives the frame
// kind indicator. Assumes all inputs are synchronous to clk.
module e1_ts0_mux
    import e1_ts0_pkg::*;
#(
    parameter int                 TS_BITS = TS0_BITS,
    parameter logic [TS_BITS-2:0] ALIGN   = FAS_WORD,
    localparam int CNT_W  = $clog2(TS_BITS),
    localparam int USER_W = TS_BITS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              ts0_mark,
    input  logic              intl_sync,
    input  logic              intl_nsync,
    input  logic [USER_W-1:0] user_bits,
    output logic              mux_out,
    output logic              sync_ind
);
    logic             ts0_start;
    logic [CNT_W-1:0] bit_idx;
    logic             frame_sync;
    logic             ts0_bit;

    e1_ts0_timing #(.TS_BITS(TS_BITS)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts0_mark   (ts0_mark),
        .ts0_start  (ts0_start),
        .bit_idx    (bit_idx),
        .frame_sync (frame_sync)
    );

    e1_ts0_byte_gen #(.TS_BITS(TS_BITS), .ALIGN(ALIGN)) u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts0_start  (ts0_start),
        .frame_sync (frame_sync),
        .bit_idx    (bit_idx),
        .intl_sync  (intl_sync),
        .intl_nsync (intl_nsync),
        .user_bits  (user_bits),
        .ts0_bit    (ts0_bit)
    );

    // Merge the timeslot-zero byte into the serial stream.
    always_comb begin
        mux_out  = ts0_mark ? ts0_bit : ser_in;
        sync_ind = frame_sync;
    end

    // R1: the indicator is set in the first cycle after reset.
    a_r1_reset_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> sync_ind);

    // R2: the alignment word fills bits 2 to 8 of sync frames.
    a_r2_align_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ts0_mark && sync_ind && bit_idx != '0) |->
            (mux_out == ALIGN[CNT_W'(TS_BITS-1) - bit_idx]));

    // R3: bit 2 of non-sync frames is forced to one.
    a_r3_bit2_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ts0_mark && !sync_ind && bit_idx == CNT_W'(1)) |-> mux_out);
endmodule

// File: tb/tb_e1_ts0_mux.sv
module tb_e1_ts0_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       ts0_mark = 1'b0;
    logic       intl_sync = 1'b0;
    logic       intl_nsync = 1'b0;
    logic [5:0] user_bits = '0;
    logic       mux_out;
    logic       sync_ind;

    int n_run = 0;
    int n_fail = 0;
    bit exp_sync = 1'b1;
    logic [7:0] lfsr = 8'hA5;
    bit finished = 1'b0;

    e1_ts0_mux dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ts0_mark(ts0_mark),
        .intl_sync(intl_sync), .intl_nsync(intl_nsync), .user_bits(user_bits),
        .mux_out(mux_out), .sync_ind(sync_ind)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive new inputs just after the falling edge; outputs are read 1 ns later.
    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] ref_byte(input bit s, input bit i_s, input bit i_n,
                                            input logic [5:0] u);
        return s ? {i_s, 7'b0011011} : {i_n, 1'b1, u};
    endfunction

    // One timeslot zero followed by a gap of serial data; checks R2-R8.
    task automatic send_frame(input bit i_s, input bit i_n, input logic [5:0] u,
                              input bit scramble, input int gap);
        logic [7:0] exp_b;
        exp_b = ref_byte(exp_sync, i_s, i_n, u);
        for (int k = 0; k < 8; k++) begin
            step();
            ts0_mark = 1'b1;
            if (k == 0) begin
                intl_sync = i_s; intl_nsync = i_n; user_bits = u;
            end else if (scramble) begin
                intl_sync = ~i_s; intl_nsync = ~i_n; user_bits = ~u; // R8
            end
            ser_in = ~exp_b[7-k]; // R5: ignored during timeslot zero
            #1;
            chk(mux_out == exp_b[7-k], exp_sync ? "R2 sync bit" : "R3 nonsync bit",
                mux_out, exp_b[7-k]);
            chk(sync_ind == exp_sync, "R4 kind during ts0", sync_ind, exp_sync);
        end
        for (int g = 0; g < gap; g++) begin
            step();
            ts0_mark = 1'b0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ser_in = lfsr[0];
            #1;
            chk(mux_out == ser_in, "R5 passthrough", mux_out, ser_in);
            if (g == 0) begin
                chk(sync_ind == exp_sync, "R7 no change in first low cycle", sync_ind, exp_sync);
                exp_sync = ~exp_sync;
            end else begin
                chk(sync_ind == exp_sync, "R7 flipped after end", sync_ind, exp_sync);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        exp_sync = 1'b1;
        step();
        ser_in = 1'b1;
        #1;
        chk(sync_ind == 1'b1, "R1 reset indicator", sync_ind, 1);
        chk(mux_out == 1'b1, "R5 passthrough after reset", mux_out, 1);
    endtask

    task automatic t_alternate();
        // R1 first frame is sync, R4 strict alternation
        send_frame(1'b1, 1'b0, 6'b101100, 1'b0, 6);
        send_frame(1'b0, 1'b1, 6'b101100, 1'b0, 6);
        send_frame(1'b0, 1'b0, 6'b010011, 1'b0, 5);
        send_frame(1'b1, 1'b0, 6'b111000, 1'b0, 5);
        send_frame(1'b1, 1'b1, 6'b000000, 1'b0, 4);
        send_frame(1'b0, 1'b0, 6'b111111, 1'b0, 4);
    endtask

    task automatic t_sampling();
        // R8 field inputs held from first cycle even when they change mid-byte
        send_frame(1'b1, 1'b0, 6'b100101, 1'b1, 4);
        send_frame(1'b0, 1'b1, 6'b011010, 1'b1, 4);
    endtask

    task automatic t_restart();
        // R6 truncated marker pulse, then a new pulse starts at bit 1
        for (int k = 0; k < 3; k++) begin
            step();
            ts0_mark = 1'b1;
            intl_sync = 1'b0; intl_nsync = 1'b0; user_bits = 6'b110011;
        end
        step();
        ts0_mark = 1'b0;
        ser_in = 1'b0;
        #1;
        chk(sync_ind == exp_sync, "R6 kind before short end", sync_ind, exp_sync);
        exp_sync = ~exp_sync;
        send_frame(1'b1, 1'b1, 6'b001110, 1'b0, 4);
    endtask

    task automatic t_midreset();
        // R9 synchronous reset while the kind is non-sync
        if (exp_sync) send_frame(1'b0, 1'b0, 6'b000111, 1'b0, 3);
        step();
        rst_n = 1'b0;
        #1;
        chk(sync_ind == 1'b0, "R9 reset is synchronous", sync_ind, 0);
        step();
        rst_n = 1'b1;
        #1;
        chk(sync_ind == 1'b1, "R9 reset restores sync", sync_ind, 1);
        exp_sync = 1'b1;
        send_frame(1'b0, 1'b1, 6'b010101, 1'b0, 4);
    endtask

    initial begin
        t_reset();
        t_alternate();
        t_sampling();
        t_restart();
        t_midreset();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule